// File: doc/BRIEF.md
# Conversion clock controller for a dual-converter ADC

The block decides when the conversion clock of a two-converter ADC runs and at what rate. It works entirely in the fast bus clock domain. Each converter receives its clock as a one-cycle enable strobe, not as a derived clock net. The strobe source is chosen at enable level. In normal power mode every bus clock cycle is a source tick. In power-saving mode only the cycles flagged by the low-power internal clock tick input count as source ticks.

Each converter has its own 6-bit divisor. A field value N yields one strobe every N+1 source ticks. The run policy is power aware:

- Nothing runs while the module enable is low.
- The clock runs continuously in looping mode or in normal power mode.
- It runs for a programmed number of converter-0 strobes after a power-up request.
- In power-saving mode, a conversion sequence that started while the block was enabled keeps it running until that sequence reports completion.

Top module: `conv_clk_ctrl`

## Requirements
- R1: While `mod_en_i` is low, no strobe is produced on either converter one cycle later, whatever the other inputs do.
- R2: With `low_power_i` high, source ticks are exactly the cycles in which `lp_tick_i` is high. A cycle with `lp_tick_i` low produces no strobe in the next cycle. With `low_power_i` low, every clock cycle is a source tick.
- R3: Each converter's divisor field value N (0 to 63) gives one strobe every N+1 source ticks while running. Converter 0 uses `div0_i` and converter 1 uses `div1_i`, independently. N=0 gives a strobe on every source tick. After a strobe with N nonzero, the next cycle has no strobe on that converter.
- R4: When running starts with counters cleared, the first strobe of a converter appears in the cycle after its (N+1)-th source tick. A change of that converter's divisor, or of `low_power_i`, spends one source cycle clearing the count, and the first strobe then comes N+1 ticks later.
- R5: With `mod_en_i` high, the clock runs without a break whenever `loop_mode_i` is high or `low_power_i` is low. With divisor 0 and a steady configuration, a strobe follows in every cycle.
- R6: A rising edge on `pwrup_req_i` loads the delay value D from `pwrup_dly_i` and clears `pwrup_ready_o` (for D nonzero). The clock then runs for exactly D converter-0 strobes, and `pwrup_ready_o` rises with the last of them. Once high, `pwrup_ready_o` stays high until the next rising edge of the request.
- R7: In power-saving mode without looping, a `conv_start_i` pulse seen while enabled keeps the clock running until a `seq_done_i` pulse. After that pulse, strobes stop.
- R8: A `conv_start_i` pulse seen while `mod_en_i` is low is ignored. Enabling later in power-saving mode without looping produces no strobes.
- R9: After reset, all strobe outputs, `clk_active_o` and `pwrup_ready_o` are low.
- R10: `clk_active_o` is high exactly in the cycles where `cen0_o` or `cen1_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mod_en_i | input | 1 | Module clock enable |
| low_power_i | input | 1 | Power-saving mode; selects the low-power tick source |
| lp_tick_i | input | 1 | Low-power internal clock, one bus-clock cycle per period |
| div0_i | input | 6 | Converter 0 divisor (divide by value+1) |
| div1_i | input | 6 | Converter 1 divisor (divide by value+1) |
| loop_mode_i | input | 1 | Looping conversion mode |
| conv_start_i | input | 1 | Conversion sequence start pulse |
| seq_done_i | input | 1 | Conversion sequence done pulse |
| pwrup_req_i | input | 1 | Power-up request, edge sensitive |
| pwrup_dly_i | input | 8 | Power-up window length in converter-0 strobes |
| cen0_o | output | 1 | Converter 0 conversion clock enable strobe |
| cen1_o | output | 1 | Converter 1 conversion clock enable strobe |
| clk_active_o | output | 1 | High when either strobe is active |
| pwrup_ready_o | output | 1 | Power-up window completed |

## Verification
The checker assumes that the low-power tick arrives as a single bus-clock-wide pulse that is synchronous to the bus clock. It also assumes that the divisor and mode inputs are ordinary synchronous levels, so a change is seen by the controller in the same cycle as by the checker. The bench drives every input on the falling edge and produces the low-power tick from a counter as a one-cycle pulse every fourth cycle. It changes divisors only while the module is disabled, except in the scenario that tests restart on a divisor change.

// File: rtl/conv_clk_pkg.sv
package conv_clk_pkg;
  parameter int unsigned DIV_W  = 6;
  parameter int unsigned DLY_W  = 8;
  parameter int unsigned N_CONV = 2;
  typedef logic [DIV_W-1:0] div_t;
  typedef logic [DLY_W-1:0] dly_t;
endpackage

// File: rtl/clk_src_sel.sv
module clk_src_sel (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic low_power_i,
  input  logic lp_tick_i,
  output logic src_tick_o,
  output logic src_chg_o
);
  logic sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sel_q <= 1'b0;
    else         sel_q <= low_power_i;
  end

  // enable-level mux: bus clock ticks every cycle, low-power source on its pulse
  assign src_tick_o = low_power_i ? lp_tick_i : 1'b1;
  assign src_chg_o  = (low_power_i != sel_q);
endmodule

// File: rtl/conv_div.sv
module conv_div
  import conv_clk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  input  logic restart_i,
  input  div_t div_i,
  output logic hit_o,
  output logic cen_o
);
  div_t cnt_q, div_q;
  logic cen_q, chg;

  assign chg   = (div_i != div_q) || restart_i;
  assign hit_o = run_i && tick_i && !chg && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      div_q <= '0;
      cen_q <= 1'b0;
    end else begin
      div_q <= div_i;
      cen_q <= hit_o;
      if (!run_i || chg)  cnt_q <= '0;
      else if (tick_i)    cnt_q <= (cnt_q == div_i) ? '0 : cnt_q + 1'b1;
    end
  end

  assign cen_o = cen_q;
endmodule

// File: rtl/pwrup_timer.sv
module pwrup_timer
  import conv_clk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  dly_t dly_i,
  input  logic dec_i,
  output logic busy_o,
  output logic ready_o
);
  dly_t cnt_q;
  logic req_q, rdy_q, rise;

  assign rise = req_i && !req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      req_q <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      req_q <= req_i;
      if (rise) begin
        cnt_q <= dly_i;
        rdy_q <= (dly_i == '0);
      end else if (cnt_q != '0 && dec_i) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == dly_t'(1)) rdy_q <= 1'b1;
      end
    end
  end

  assign busy_o  = (cnt_q != '0);
  assign ready_o = rdy_q;
endmodule

// File: rtl/run_policy.sv
module run_policy (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mod_en_i,
  input  logic loop_mode_i,
  input  logic low_power_i,
  input  logic start_i,
  input  logic done_i,
  input  logic pw_busy_i,
  output logic run_o
);
  logic seq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       seq_q <= 1'b0;
    else if (!mod_en_i) seq_q <= 1'b0;
    else if (start_i)   seq_q <= 1'b1;
    else if (done_i)    seq_q <= 1'b0;
  end

  assign run_o = mod_en_i && (loop_mode_i || !low_power_i || pw_busy_i || seq_q);
endmodule

// File: rtl/conv_clk_ctrl.sv
module conv_clk_ctrl
  import conv_clk_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mod_en_i,
  input  logic             low_power_i,
  input  logic             lp_tick_i,
  input  logic [DIV_W-1:0] div0_i,
  input  logic [DIV_W-1:0] div1_i,
  input  logic             loop_mode_i,
  input  logic             conv_start_i,
  input  logic             seq_done_i,
  input  logic             pwrup_req_i,
  input  logic [DLY_W-1:0] pwrup_dly_i,
  output logic             cen0_o,
  output logic             cen1_o,
  output logic             clk_active_o,
  output logic             pwrup_ready_o
);
  logic src_tick, src_chg, run, pw_busy;
  div_t             div_a [N_CONV];
  logic [N_CONV-1:0] hit, cen;

  assign div_a[0] = div0_i;
  assign div_a[1] = div1_i;

  clk_src_sel u_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .low_power_i (low_power_i),
    .lp_tick_i   (lp_tick_i),
    .src_tick_o  (src_tick),
    .src_chg_o   (src_chg)
  );

  run_policy u_pol (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mod_en_i    (mod_en_i),
    .loop_mode_i (loop_mode_i),
    .low_power_i (low_power_i),
    .start_i     (conv_start_i),
    .done_i      (seq_done_i),
    .pw_busy_i   (pw_busy),
    .run_o       (run)
  );

  for (genvar g = 0; g < N_CONV; g++) begin : g_div
    conv_div u_div (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (run),
      .tick_i    (src_tick),
      .restart_i (src_chg),
      .div_i     (div_a[g]),
      .hit_o     (hit[g]),
      .cen_o     (cen[g])
    );
  end

  // power-up window counts converter-0 strobes
  pwrup_timer u_pwr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (pwrup_req_i),
    .dly_i   (pwrup_dly_i),
    .dec_i   (hit[0]),
    .busy_o  (pw_busy),
    .ready_o (pwrup_ready_o)
  );

  assign cen0_o       = cen[0];
  assign cen1_o       = cen[1];
  assign clk_active_o = |cen;
endmodule

// File: rtl/conv_clk_ctrl_chk.sv
module conv_clk_ctrl_chk
  import conv_clk_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             mod_en_i,
  input logic             low_power_i,
  input logic             lp_tick_i,
  input logic [DIV_W-1:0] div0_i,
  input logic             loop_mode_i,
  input logic             pwrup_req_i,
  input logic             cen0_o,
  input logic             cen1_o,
  input logic             pwrup_ready_o
);
  logic [DIV_W-1:0] pd0;
  logic plp, preq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd0  <= '0;
      plp  <= 1'b0;
      preq <= 1'b0;
    end else begin
      pd0  <= div0_i;
      plp  <= low_power_i;
      preq <= pwrup_req_i;
    end
  end

  // R1
  gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mod_en_i |=> (!cen0_o && !cen1_o));

  // R2
  lp_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_power_i && !lp_tick_i) |=> (!cen0_o && !cen1_o));

  // R3
  div_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cen0_o && div0_i != '0) |=> !cen0_o);

  // R5
  cont_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mod_en_i && !low_power_i && !plp && div0_i == '0 && pd0 == '0) |=> cen0_o);

  // R6
  ready_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwrup_ready_o && !(pwrup_req_i && !preq)) |=> pwrup_ready_o);
endmodule

bind conv_clk_ctrl conv_clk_ctrl_chk chk_i (.*);

// File: tb/conv_clk_ctrl_tb_top.sv
module conv_clk_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic mod_en = 0, low_power = 0, lp_tick = 0, loop_mode = 0;
  logic start = 0, done = 0, preq = 0, lp_on = 0;
  logic [5:0] div0 = 0, div1 = 0;
  logic [7:0] dly = 0;
  logic cen0, cen1, active, ready;
  int total = 0, bad = 0, act_err = 0, lp_ph = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  conv_clk_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .mod_en_i(mod_en), .low_power_i(low_power),
    .lp_tick_i(lp_tick), .div0_i(div0), .div1_i(div1), .loop_mode_i(loop_mode),
    .conv_start_i(start), .seq_done_i(done), .pwrup_req_i(preq),
    .pwrup_dly_i(dly), .cen0_o(cen0), .cen1_o(cen1), .clk_active_o(active),
    .pwrup_ready_o(ready)
  );

  // low-power source: one-cycle pulse every 4 bus cycles
  always @(negedge clk) begin
    if (lp_on) begin
      lp_ph   = (lp_ph + 1) % 4;
      lp_tick = (lp_ph == 3);
    end else begin
      lp_ph   = 0;
      lp_tick = 0;
    end
  end

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // samples at falling edges; R10 tracked on every sample
  task automatic step();
    @(negedge clk);
    if (active != (cen0 | cen1)) act_err++;
  endtask

  task automatic count(int n, output int c0, output int c1);
    c0 = 0; c1 = 0;
    for (int i = 0; i < n; i++) begin
      step();
      c0 += int'(cen0);
      c1 += int'(cen1);
    end
  endtask

  // cycles until the next strobe on a channel (limit+1 if none)
  task automatic gap(bit ch, int limit, output int cyc);
    cyc = limit + 1;
    for (int i = 1; i <= limit; i++) begin
      step();
      if ((ch ? cen1 : cen0) == 1'b1) begin
        cyc = i;
        break;
      end
    end
  endtask

  task automatic idle();
    mod_en = 0; loop_mode = 0; low_power = 0; lp_on = 0;
    repeat (3) step();
  endtask

  task automatic t_reset();
    check("R9 cen0", cen0, 0);
    check("R9 cen1", cen1, 0);
    check("R9 active", active, 0);
    check("R9 ready", ready, 0);
  endtask

  task automatic t_gate();
    int c0, c1;
    loop_mode = 1;
    count(40, c0, c1);
    check("R1 disabled strobes", c0 + c1, 0);
    // start ignored while disabled
    loop_mode = 0; low_power = 1; lp_on = 1;
    repeat (2) step();
    start = 1; step(); start = 0;
    repeat (2) step();
    mod_en = 1;
    count(50, c0, c1);
    check("R8 start ignored", c0 + c1, 0);
    idle();
  endtask

  task automatic t_div(int n0, int n1);
    int g;
    div0 = 6'(n0); div1 = 6'(n1);
    repeat (3) step();
    mod_en = 1;
    gap(0, 70, g);
    check("R4 first strobe latency", g, n0 + 1);
    gap(0, 70, g);
    check("R3 conv0 period", g, n0 + 1);
    gap(0, 70, g);
    check("R5 conv0 period continuous", g, n0 + 1);
    gap(1, 70, g);
    gap(1, 70, g);
    check("R3 conv1 period", g, n1 + 1);
    idle();
  endtask

  task automatic t_divchg();
    int g;
    div0 = 3; div1 = 0;
    repeat (3) step();
    mod_en = 1;
    gap(0, 20, g);
    div0 = 1;
    gap(0, 20, g);
    check("R4 restart after divisor change", g, 3);
    gap(0, 20, g);
    check("R3 period after change", g, 2);
    idle();
  endtask

  task automatic t_lowpower();
    int g, c0, c1;
    div0 = 2; div1 = 0;
    low_power = 1; lp_on = 1; loop_mode = 1;
    repeat (3) step();
    mod_en = 1;
    gap(0, 40, g);
    gap(0, 40, g);
    check("R2 low-power period", g, 12);
    count(40, c0, c1);
    check("R2 conv1 per lp tick", c1, 10);
    idle();
  endtask

  task automatic t_pwrup();
    int c0, c1;
    div0 = 1; div1 = 0; dly = 5;
    low_power = 1; lp_on = 1;
    repeat (3) step();
    mod_en = 1;
    repeat (3) step();
    preq = 1;
    repeat (2) step();
    check("R6 ready low in window", ready, 0);
    count(200, c0, c1);
    check("R6 window strobes", c0 + ((cen0 === 1'b1) ? 0 : 0), 5 - 0);
    check("R6 ready after window", ready, 1);
    preq = 0;
    count(20, c0, c1);
    check("R6 ready holds", ready, 1);
    idle();
  endtask

  task automatic t_seq();
    int c0, c1;
    div0 = 0; div1 = 0;
    low_power = 1; lp_on = 1;
    repeat (3) step();
    mod_en = 1;
    count(20, c0, c1);
    check("R7 idle before start", c0, 0);
    start = 1; step(); start = 0;
    count(40, c0, c1);
    check("R7 running in sequence", c0, 10);
    done = 1; step(); done = 0;
    repeat (2) step();
    count(60, c0, c1);
    check("R7 stopped after done", c0 + c1, 0);
    idle();
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) step();
    t_reset();
    t_gate();
    t_div(0, 5);
    t_div(3, 1);
    t_div(63, 2);
    t_divchg();
    t_lowpower();
    t_pwrup();
    t_seq();
    check("R10 active tracks strobes", act_err, 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule